// File: doc/BRIEF.md
# Keyed Configuration-Port Watchdog Timer

This block is a countdown watchdog whose settings sit behind a pair of byte-wide ports: an index port that names a register and a data port that reads or writes it. Nothing behind the ports can be reached until a two-byte key has gone into the index port. A page register then has to point at the watchdog page. A closing code written to the index port shuts access again. A supervisor therefore unlocks, selects the page, programs the unit, the timeout and the reload sources, enables the timer, and locks.

Once enabled, the counter steps down on either a one-second or a one-minute tick. Both ticks are supplied from outside. When the count runs out, a timeout output rises and holds. The software keepalive is a rewrite of the timer register. As an option, keyboard or mouse interrupt pulses can reload the counter from the last value written.

Top module: `wdt_cfgport`

## Requirements
- R1: Access opens only after two back-to-back index-port writes of 0x87. While access is closed, the data port reads 0xFF and data-port writes change nothing.
- R2: An index-port write of any other value between the two key bytes cancels the partial key, so the next 0x87 counts as the first byte again.
- R3: An index-port write of 0xAA closes access. Afterwards the data port reads 0xFF and data-port writes are ignored.
- R4: Index 0x07 is the page register and can always be read and written while access is open. The watchdog registers answer only while the page holds 0x08. With any other page, writes to them are dropped and they read 0x00.
- R5: Register 0x30 bit 0 is the enable (1 runs the timer). It reads back in bit 0 with all other bits zero.
- R6: Register 0xF5 bit 3 selects the tick: 0 for sec_tick, 1 for min_tick. The tick that is not selected has no effect. The bit reads back in bit 3.
- R7: Writing register 0xF6 loads the counter, and reading it returns the live count. While enabled, each selected tick lowers a nonzero count by one. While disabled, the count holds.
- R8: timeout rises at the same clock edge at which the count steps from 1 to 0. It stays high until register 0xF6 is written or the enable is written to 0.
- R9: A value of 0 written to register 0xF6 stops the count, and no timeout follows from it.
- R10: After reset, access is closed, the page is 0x00, the watchdog is disabled, the unit is minutes, the timer holds 5, both interrupt reloads are off, and timeout is low.
- R11: Register 0xF7 bit 6 lets a kbd_irq pulse reload the counter from the last value written to 0xF6, and bit 7 does the same for mouse_irq. A reload happens only while the watchdog is enabled and not timed out. A pulse whose bit is clear changes nothing. A reload takes precedence over a tick in the same cycle.
- R12: rdata follows the current index with no clock delay. A port write takes effect at the clock edge on which its strobe is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_we | input | 1 | Index-port write strobe |
| data_we | input | 1 | Data-port write strobe |
| wdata | input | 8 | Write byte for either port |
| rdata | output | 8 | Data-port read value |
| sec_tick | input | 1 | One-cycle pulse once per second |
| min_tick | input | 1 | One-cycle pulse once per minute |
| kbd_irq | input | 1 | Keyboard interrupt pulse |
| mouse_irq | input | 1 | Mouse interrupt pulse |
| timeout | output | 1 | Watchdog expired |

## Verification
Every register effect, the counter step and the rise or fall of timeout become visible right after the single clock edge that samples the strobe or tick. The read value is combinational, so a read needs no extra cycle after the index is written. The bench raises each strobe for exactly one cycle, driven between falling edges. It samples shortly after the falling edge that ends the strobe, which lies after exactly one rising edge. A bench model advances its expected count and timeout by one step per strobe under the same rule, including the random mix of ticks, interrupt pulses and reloads.

// File: rtl/wdt_cfgport.sv
module wdt_cfgport #(
  parameter logic [7:0] KEY_CODE  = 8'h87,
  parameter logic [7:0] LOCK_CODE = 8'hAA,
  parameter logic [7:0] PAGE_IDX  = 8'h07,
  parameter logic [7:0] WDT_PAGE  = 8'h08,
  parameter logic [7:0] EN_IDX    = 8'h30,
  parameter logic [7:0] UNIT_IDX  = 8'hF5,
  parameter logic [7:0] TMR_IDX   = 8'hF6,
  parameter logic [7:0] SRC_IDX   = 8'hF7,
  parameter logic [7:0] DEF_TIME  = 8'd5,
  parameter bit         DEF_MIN   = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_we,
  input  logic       data_we,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       sec_tick,
  input  logic       min_tick,
  input  logic       kbd_irq,
  input  logic       mouse_irq,
  output logic       timeout
);

  logic       key_seen, unlocked;
  logic [7:0] idx, page, cnt, reload;
  logic       en, unit_min, kbd_en, ms_en;

  wire pg_ok   = unlocked && (page == WDT_PAGE);
  wire wr      = data_we && unlocked;
  wire wr_page = wr && (idx == PAGE_IDX);
  wire wr_en   = wr && pg_ok && (idx == EN_IDX);
  wire wr_unit = wr && pg_ok && (idx == UNIT_IDX);
  wire wr_tmr  = wr && pg_ok && (idx == TMR_IDX);
  wire wr_src  = wr && pg_ok && (idx == SRC_IDX);
  wire tick    = unit_min ? min_tick : sec_tick;
  wire irq_hit = (kbd_irq && kbd_en) || (mouse_irq && ms_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_seen <= 1'b0;
      unlocked <= 1'b0;
      idx      <= 8'h00;
    end else if (idx_we) begin
      if (wdata == KEY_CODE) begin
        key_seen <= !key_seen;
        if (key_seen) unlocked <= 1'b1;
      end else begin
        key_seen <= 1'b0;
        if (wdata == LOCK_CODE) unlocked <= 1'b0;
        else if (unlocked)      idx <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page     <= 8'h00;
      en       <= 1'b0;
      unit_min <= DEF_MIN;
      kbd_en   <= 1'b0;
      ms_en    <= 1'b0;
    end else begin
      if (wr_page) page <= wdata;
      if (wr_en)   en <= wdata[0];
      if (wr_unit) unit_min <= wdata[3];
      if (wr_src) begin
        kbd_en <= wdata[6];
        ms_en  <= wdata[7];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= DEF_TIME;
      reload  <= DEF_TIME;
      timeout <= 1'b0;
    end else if (wr_tmr) begin
      cnt     <= wdata;
      reload  <= wdata;
      timeout <= 1'b0;
    end else if (wr_en && !wdata[0]) begin
      timeout <= 1'b0;
    end else if (en && !timeout && irq_hit) begin
      cnt <= reload;
    end else if (en && tick && cnt != 8'h00) begin
      cnt <= cnt - 8'h01;
      if (cnt == 8'h01) timeout <= 1'b1;
    end
  end

  always_comb begin
    if (!unlocked)               rdata = 8'hFF;
    else if (idx == PAGE_IDX)    rdata = page;
    else if (page != WDT_PAGE)   rdata = 8'h00;
    else begin
      case (idx)
        EN_IDX:   rdata = {7'b0, en};
        UNIT_IDX: rdata = {4'b0, unit_min, 3'b0};
        TMR_IDX:  rdata = cnt;
        SRC_IDX:  rdata = {ms_en, kbd_en, 6'b0};
        default:  rdata = 8'h00;
      endcase
    end
  end

endmodule

// File: rtl/wdt_cfgport_chk.sv
module wdt_cfgport_chk #(
  parameter logic [7:0] KEY_CODE  = 8'h87,
  parameter logic [7:0] LOCK_CODE = 8'hAA,
  parameter logic [7:0] WDT_PAGE  = 8'h08,
  parameter logic [7:0] EN_IDX    = 8'h30,
  parameter logic [7:0] TMR_IDX   = 8'hF6
) (
  input logic       clk,
  input logic       rst_n,
  input logic       idx_we,
  input logic       data_we,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       unlocked,
  input logic [7:0] page,
  input logic [7:0] idx,
  input logic [7:0] cnt,
  input logic       en,
  input logic       timeout,
  input logic       sec_tick,
  input logic       min_tick,
  input logic       kbd_irq,
  input logic       mouse_irq
);

  p_key_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(idx_we && wdata == KEY_CODE));

  p_closed_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |-> rdata == 8'hFF);

  p_lock_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_we && wdata == LOCK_CODE) |=> !unlocked);

  p_timeout_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> ($past(cnt) == 8'h01 && cnt == 8'h00));

  p_timeout_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(timeout) |-> $past(data_we && unlocked && page == WDT_PAGE &&
                             (idx == TMR_IDX || (idx == EN_IDX && !wdata[0]))));

  p_zero_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 8'h00 && !timeout) |=> !timeout);

  p_hold_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_we && !sec_tick && !min_tick && !kbd_irq && !mouse_irq) |=> $stable(cnt));

  p_disabled_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !data_we) |=> $stable(cnt));

endmodule

bind wdt_cfgport wdt_cfgport_chk #(
  .KEY_CODE(KEY_CODE), .LOCK_CODE(LOCK_CODE), .WDT_PAGE(WDT_PAGE),
  .EN_IDX(EN_IDX), .TMR_IDX(TMR_IDX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .data_we(data_we),
  .wdata(wdata), .rdata(rdata), .unlocked(unlocked), .page(page),
  .idx(idx), .cnt(cnt), .en(en), .timeout(timeout),
  .sec_tick(sec_tick), .min_tick(min_tick), .kbd_irq(kbd_irq),
  .mouse_irq(mouse_irq)
);

// File: tb/sim_wdt_cfgport.sv
module sim_wdt_cfgport;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       idx_we = 1'b0, data_we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       sec_tick = 1'b0, min_tick = 1'b0, kbd_irq = 1'b0, mouse_irq = 1'b0;
  logic       timeout;

  int nchk = 0, nerr = 0;
  logic [7:0] m_cnt, m_rel;
  logic       m_to;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_cfgport u0 (
    .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .data_we(data_we),
    .wdata(wdata), .rdata(rdata), .sec_tick(sec_tick), .min_tick(min_tick),
    .kbd_irq(kbd_irq), .mouse_irq(mouse_irq), .timeout(timeout)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic idx_wr(input logic [7:0] v);
    @(negedge clk); idx_we = 1'b1; wdata = v;
    @(negedge clk); idx_we = 1'b0; #1;
  endtask

  task automatic data_wr(input logic [7:0] v);
    @(negedge clk); data_we = 1'b1; wdata = v;
    @(negedge clk); data_we = 1'b0; #1;
  endtask

  task automatic reg_wr(input logic [7:0] i, input logic [7:0] v);
    idx_wr(i); data_wr(v);
  endtask

  task automatic reg_rd(input logic [7:0] i, output logic [7:0] v);
    idx_wr(i); v = rdata;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: sec_tick = 1'b1;
      1: min_tick = 1'b1;
      2: kbd_irq = 1'b1;
      default: mouse_irq = 1'b1;
    endcase
    @(negedge clk);
    sec_tick = 1'b0; min_tick = 1'b0; kbd_irq = 1'b0; mouse_irq = 1'b0; #1;
  endtask

  function automatic logic [8:0] model_tick(input logic [7:0] c, input logic t);
    if (t || c == 8'h00) return {t, c};
    return {c == 8'h01, c - 8'h01};
  endfunction

  function automatic logic [7:0] model_irq(input logic [7:0] c, input logic t, input logic [7:0] r);
    return t ? c : r;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    nerr++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; #1;

    chk("R10 timeout at reset", {7'b0, timeout}, 8'h00);
    chk("R1 closed read", rdata, 8'hFF);

    data_wr(8'h08);
    idx_wr(8'h87); idx_wr(8'h12); idx_wr(8'h87);
    chk("R2 broken key stays closed", rdata, 8'hFF);
    idx_wr(8'h87);
    reg_rd(8'h07, v); chk("R1 open after key pair, R10 page 0", v, 8'h00);

    reg_rd(8'hF6, v); chk("R4 off-page read", v, 8'h00);
    data_wr(8'h33);
    reg_wr(8'h07, 8'h08);
    reg_rd(8'h07, v); chk("R4 page readback", v, 8'h08);
    reg_rd(8'hF6, v); chk("R4/R10 off-page write dropped, default time", v, 8'h05);
    reg_rd(8'hF5, v); chk("R10 unit minutes", v, 8'h08);
    reg_rd(8'h30, v); chk("R10 disabled", v, 8'h00);
    reg_rd(8'hF7, v); chk("R10 reload sources off", v, 8'h00);

    reg_wr(8'hF5, 8'hF7);
    reg_rd(8'hF5, v); chk("R6 unit seconds readback", v, 8'h00);
    reg_wr(8'hF6, 8'h03);
    reg_wr(8'h30, 8'hFF);
    reg_rd(8'h30, v); chk("R5 enable readback", v, 8'h01);
    idx_wr(8'hF6);
    pulse(1); chk("R6 min_tick ignored in seconds", rdata, 8'h03);
    pulse(0); chk("R7 step", rdata, 8'h02);
    pulse(0); chk("R7 step", rdata, 8'h01);
    chk("R8 no early timeout", {7'b0, timeout}, 8'h00);
    pulse(0); chk("R8 reach zero", rdata, 8'h00);
    chk("R8 timeout rises", {7'b0, timeout}, 8'h01);
    pulse(0); chk("R8 timeout held", {7'b0, timeout}, 8'h01);
    data_wr(8'h04);
    chk("R8 rewrite clears", {7'b0, timeout}, 8'h00);
    chk("R7 load", rdata, 8'h04);

    reg_wr(8'h30, 8'h00);
    idx_wr(8'hF6); pulse(0); pulse(0);
    chk("R7 disabled holds", rdata, 8'h04);
    reg_wr(8'h30, 8'h01);
    reg_wr(8'hF6, 8'h01); pulse(0);
    chk("R8 timeout again", {7'b0, timeout}, 8'h01);
    reg_wr(8'h30, 8'h00);
    chk("R8 disable clears", {7'b0, timeout}, 8'h00);
    reg_wr(8'h30, 8'h01);

    reg_wr(8'hF6, 8'h00); pulse(0); pulse(0);
    chk("R9 zero no timeout", {7'b0, timeout}, 8'h00);
    chk("R9 zero holds", rdata, 8'h00);

    reg_wr(8'hF7, 8'h40);
    reg_wr(8'hF6, 8'h06); pulse(0); pulse(0); pulse(0);
    chk("R7 three steps", rdata, 8'h03);
    pulse(3); chk("R11 mouse ignored", rdata, 8'h03);
    pulse(2); chk("R11 kbd reload", rdata, 8'h06);
    reg_wr(8'hF7, 8'h80);
    reg_rd(8'hF7, v); chk("R11 source readback", v, 8'h80);
    idx_wr(8'hF6); pulse(0);
    pulse(2); chk("R11 kbd ignored", rdata, 8'h05);
    pulse(3); chk("R11 mouse reload", rdata, 8'h06);

    reg_wr(8'hF5, 8'h08);
    reg_wr(8'hF6, 8'h02);
    pulse(0); chk("R6 sec_tick ignored in minutes", rdata, 8'h02);
    pulse(1); chk("R6 min step", rdata, 8'h01);

    idx_wr(8'hAA);
    chk("R3 closed read", rdata, 8'hFF);
    data_wr(8'h00);
    pulse(1);
    chk("R3 write after lock ignored", {7'b0, timeout}, 8'h01);

    idx_wr(8'h87); idx_wr(8'h87);
    reg_wr(8'hF5, 8'h00);
    reg_wr(8'hF7, 8'h40);
    reg_wr(8'hF6, 8'h07);
    m_cnt = 8'h07; m_rel = 8'h07; m_to = 1'b0;
    idx_wr(8'hF6);
    chk("R12 read same cycle", rdata, 8'h07);
    for (int k = 0; k < 400; k++) begin
      int op;
      logic [8:0] r;
      op = $urandom % 8;
      if (op < 4) begin
        pulse(0); r = model_tick(m_cnt, m_to); m_to = r[8]; m_cnt = r[7:0];
      end else if (op == 4) begin
        pulse(1);
      end else if (op == 5) begin
        pulse(2); m_cnt = model_irq(m_cnt, m_to, m_rel);
      end else if (op == 6) begin
        pulse(3);
      end else begin
        v = 8'($urandom % 6); data_wr(v);
        m_cnt = v; m_rel = v; m_to = 1'b0;
      end
      chk("R7 random count", rdata, m_cnt);
      chk("R8 random timeout", {7'b0, timeout}, {7'b0, m_to});
    end

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial void'($urandom(32'd1234));
endmodule